// File: doc/BRIEF.md
# Register-Write Command Executor

This block walks a queue of 64-bit commands held in word-addressed memory and turns them into register writes on a simple write bus. Software sets a start line and an end line, then starts the engine with the end-line write. The engine fetches one 32-bit word at a time, decodes each two-word command, and then either issues writes, waits a number of microseconds, hands a scanline condition to an external wait unit, or skips the command. It never reads a register. The memory read request and the register write are valid/ready streams. A stream's valid, once raised, stays high with its payload unchanged until ready is seen in the same cycle. A downstream stall therefore holds the engine in place and loses nothing. Control and status pins are plain levels.

The start and end of the queue are given as 64-byte line indices, so the engine runs from word `head*16` up to, but not including, word `tail*16`. Any fill after the last command is zero and decodes as a no-op. Command word 0 (the lower word address) is the operand, and word 1 holds the opcode in bits 31:24.

Top module: `regcmd_exec`

## Requirements
- R1: After reset, busy, err, mem_rd_valid, wr_valid and sl_start are all 0.
- R2: A cycle with ctl_tail_we and ctl_enable both high while idle raises busy on the next cycle. The engine then runs commands from word ctl_head*16 up to word ctl_tail*16, and busy falls when that word is reached. A ctl_tail_we with ctl_enable low starts nothing. When head equals tail, no command runs.
- R3: Every command is two words and starts on an even word. Word 1 bits 31:24 are the opcode. Opcode 0x00 is a no-op and makes no bus traffic, so a zero-filled tail of a line does nothing.
- R4: Opcode 0x01 is a direct write. It makes exactly one bus write, with wr_addr = word1[19:0], wr_data = word0 and wr_be = word1[23:20]. Bit n of wr_be covers data byte n.
- R5: Opcode 0x09 is an indexed write. Word 0 is a count N, and the N following words are written in order to the single register word1[19:0] with wr_be = 4'hF. When N is odd, one pad word follows and is skipped. When N is 0, nothing is written. The next command starts right after the payload and any pad.
- R6: Opcode 0x02 holds the engine for word0 microseconds. One microsecond is TICKS_PER_US clock cycles, so a wait of N lasts exactly N*TICKS_PER_US cycles longer than a wait of 0.
- R7: Opcodes 0x03 to 0x06 are scanline conditions. Each gives a one-cycle sl_start pulse with sl_op = opcode[2:0], sl_lo = word0 and sl_hi = word1[19:0]. The engine issues nothing further until sl_done is seen.
- R8: Any other opcode, including 0x07, 0x08 and 0x0A, sets the sticky err flag and is skipped as a two-word command. err clears at the next start.
- R9: While wr_valid is high and wr_ready is low, wr_valid, wr_addr, wr_data and wr_be stay unchanged. The same holds for the memory request while mem_rd_ready is low. At most one write is accepted per cycle.
- R10: ctl_halt together with ctl_enable while busy ends the run at the next command boundary, or at once during a microsecond or scanline wait. After that, busy is low and no further writes are made. ctl_halt with ctl_enable low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_enable | input | 1 | Qualifies a start or a halt |
| ctl_halt | input | 1 | Halt request, used only with ctl_enable |
| ctl_tail_we | input | 1 | End-line write, starts a run when idle |
| ctl_head | input | LINE_W | First 64-byte line of the queue |
| ctl_tail | input | LINE_W | Line at which the run stops |
| busy | output | 1 | Run in progress |
| err | output | 1 | Sticky unknown-opcode flag for this run |
| mem_rd_valid | output | 1 | Memory word request valid |
| mem_rd_ready | input | 1 | Memory accepts request |
| mem_rd_addr | output | LINE_W+4 | Word address of the request |
| mem_rsp_valid | input | 1 | Read data valid, one per accepted request |
| mem_rsp_data | input | 32 | Read data |
| wr_valid | output | 1 | Register write valid |
| wr_ready | input | 1 | Register bus accepts write |
| wr_addr | output | 20 | Register offset |
| wr_data | output | 32 | Write data |
| wr_be | output | 4 | Byte enables |
| sl_start | output | 1 | One-cycle request to the scanline wait unit |
| sl_op | output | 3 | Low opcode bits selecting the wait kind |
| sl_lo | output | 32 | Operand word of the wait |
| sl_hi | output | 20 | Low 20 bits of word 1 of the wait |
| sl_done | input | 1 | Wait unit reports the condition met |

## Verification
A fetch pointer that is off by one word shows at once as a wrong wr_addr or wr_data on the next write, or as an err flag where none was expected, because a payload word gets decoded as an opcode. A wrong count in an indexed write shows as one write too many or too few. It also shifts every following command, and that is seen before busy falls. Timer or halt faults show as a busy interval of the wrong length, which is measured to the exact cycle against a zero-length wait. A payload that changes during a stall shows within the stall cycles.

// File: rtl/regcmd_pkg.sv
package regcmd_pkg;
  localparam int DW  = 32;
  localparam int RAW = 20;

  localparam logic [7:0] OP_NOP        = 8'h00;
  localparam logic [7:0] OP_WRITE      = 8'h01;
  localparam logic [7:0] OP_USEC       = 8'h02;
  localparam logic [7:0] OP_LINE_FIRST = 8'h03;
  localparam logic [7:0] OP_LINE_LAST  = 8'h06;
  localparam logic [7:0] OP_BURST      = 8'h09;

  typedef enum logic [2:0] {K_NOP, K_WRITE, K_BURST, K_USEC, K_LINE, K_BAD} kind_e;

  typedef enum logic [3:0] {
    S_IDLE, S_NEXT, S_REQ, S_RSP, S_EXEC, S_WR, S_UWAIT, S_LSTART, S_LWAIT
  } state_e;

  typedef enum logic [1:0] {P_W0, P_W1, P_DATA} phase_e;
endpackage

// File: rtl/regcmd_decode.sv
module regcmd_decode
  import regcmd_pkg::*;
(
  input  logic [7:0] opcode,
  output kind_e      kind
);
  always_comb begin
    if (opcode == OP_NOP)                                       kind = K_NOP;
    else if (opcode == OP_WRITE)                                kind = K_WRITE;
    else if (opcode == OP_BURST)                                kind = K_BURST;
    else if (opcode == OP_USEC)                                 kind = K_USEC;
    else if (opcode >= OP_LINE_FIRST && opcode <= OP_LINE_LAST) kind = K_LINE;
    else                                                        kind = K_BAD;
  end
endmodule

// File: rtl/regcmd_usec_timer.sv
module regcmd_usec_timer #(
  parameter int TICKS_PER_US = 100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic        run,
  input  logic [31:0] count,
  output logic        done
);
  localparam int TW = $clog2(TICKS_PER_US + 1);
  localparam logic [TW-1:0] TLAST = TW'(TICKS_PER_US - 1);

  logic [31:0]   us_left;
  logic [TW-1:0] tick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      us_left <= '0;
      tick    <= '0;
    end else if (load) begin
      us_left <= count;
      tick    <= '0;
    end else if (run && us_left != 32'd0) begin
      if (tick == TLAST) begin
        tick    <= '0;
        us_left <= us_left - 32'd1;
      end else begin
        tick <= tick + 1'b1;
      end
    end
  end

  assign done = (us_left == 32'd0);

  // R6: the sub-microsecond divider never passes its last tick
  a_r6_tick_range: assert property (@(posedge clk) disable iff (!rst_n)
    tick <= TLAST);
endmodule

// File: rtl/regcmd_core.sv
module regcmd_core
  import regcmd_pkg::*;
#(
  parameter int LINE_W = 4,
  localparam int WA = LINE_W + 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_enable,
  input  logic              ctl_halt,
  input  logic              ctl_tail_we,
  input  logic [LINE_W-1:0] ctl_head,
  input  logic [LINE_W-1:0] ctl_tail,
  output logic              busy,
  output logic              err,
  output logic              mem_rd_valid,
  input  logic              mem_rd_ready,
  output logic [WA-1:0]     mem_rd_addr,
  input  logic              mem_rsp_valid,
  input  logic [DW-1:0]     mem_rsp_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [RAW-1:0]    wr_addr,
  output logic [DW-1:0]     wr_data,
  output logic [3:0]        wr_be,
  output logic              sl_start,
  output logic [2:0]        sl_op,
  output logic [DW-1:0]     sl_lo,
  output logic [RAW-1:0]    sl_hi,
  input  logic              sl_done,
  output logic [7:0]        opcode,
  input  kind_e             kind,
  output logic              tmr_load,
  output logic              tmr_run,
  output logic [DW-1:0]     tmr_count,
  input  logic              tmr_done
);
  state_e           state;
  phase_e           phase;
  logic [WA-1:0]    ptr, tail_w;
  logic [DW-1:0]    lo, hi, cnt, wd_r;
  logic [RAW-1:0]   wa_r;
  logic [3:0]       wb_r;
  logic             err_r, halt_pend;

  logic start_go;
  assign start_go = (state == S_IDLE) && ctl_tail_we && ctl_enable;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      phase     <= P_W0;
      ptr       <= '0;
      tail_w    <= '0;
      lo        <= '0;
      hi        <= '0;
      cnt       <= '0;
      wd_r      <= '0;
      wa_r      <= '0;
      wb_r      <= '0;
      err_r     <= 1'b0;
      halt_pend <= 1'b0;
    end else begin
      if (state != S_IDLE && ctl_enable && ctl_halt) halt_pend <= 1'b1;
      unique case (state)
        S_IDLE: if (start_go) begin
          ptr       <= {ctl_head, 4'b0000};
          tail_w    <= {ctl_tail, 4'b0000};
          err_r     <= 1'b0;
          halt_pend <= 1'b0;
          state     <= S_NEXT;
        end
        S_NEXT: begin
          if (halt_pend || ptr == tail_w) state <= S_IDLE;
          else begin
            phase <= P_W0;
            state <= S_REQ;
          end
        end
        S_REQ: if (mem_rd_ready) begin
          ptr   <= ptr + 1'b1;
          state <= S_RSP;
        end
        S_RSP: if (mem_rsp_valid) begin
          unique case (phase)
            P_W0: begin
              lo    <= mem_rsp_data;
              phase <= P_W1;
              state <= S_REQ;
            end
            P_W1: begin
              hi    <= mem_rsp_data;
              state <= S_EXEC;
            end
            default: begin
              wd_r  <= mem_rsp_data;
              cnt   <= cnt - 32'd1;
              state <= S_WR;
            end
          endcase
        end
        S_EXEC: begin
          unique case (kind)
            K_WRITE: begin
              wa_r  <= hi[19:0];
              wd_r  <= lo;
              wb_r  <= hi[23:20];
              state <= S_WR;
            end
            K_BURST: begin
              wa_r <= hi[19:0];
              wb_r <= 4'hF;
              cnt  <= lo;
              if (lo == 32'd0) state <= S_NEXT;
              else begin
                phase <= P_DATA;
                state <= S_REQ;
              end
            end
            K_USEC:  state <= S_UWAIT;
            K_LINE:  state <= S_LSTART;
            K_BAD: begin
              err_r <= 1'b1;
              state <= S_NEXT;
            end
            default: state <= S_NEXT;
          endcase
        end
        S_WR: if (wr_ready) begin
          if (phase == P_DATA && cnt != 32'd0) state <= S_REQ;
          else begin
            if (ptr[0]) ptr <= ptr + 1'b1;   // skip pad of an odd burst
            state <= S_NEXT;
          end
        end
        S_UWAIT: begin
          if (halt_pend)     state <= S_IDLE;
          else if (tmr_done) state <= S_NEXT;
        end
        S_LSTART: state <= S_LWAIT;
        S_LWAIT: begin
          if (sl_done)        state <= S_NEXT;
          else if (halt_pend) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy         = (state != S_IDLE);
  assign err          = err_r;
  assign mem_rd_valid = (state == S_REQ);
  assign mem_rd_addr  = ptr;
  assign wr_valid     = (state == S_WR);
  assign wr_addr      = wa_r;
  assign wr_data      = wd_r;
  assign wr_be        = wb_r;
  assign sl_start     = (state == S_LSTART);
  assign sl_op        = hi[26:24];
  assign sl_lo        = lo;
  assign sl_hi        = hi[19:0];
  assign opcode       = hi[31:24];
  assign tmr_load     = (state == S_EXEC) && (kind == K_USEC);
  assign tmr_run      = (state == S_UWAIT);
  assign tmr_count    = lo;

  // R9: a stalled write keeps its payload
  a_r9_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data) && $stable(wr_be));
  // R9: a stalled memory request keeps its address
  a_r9_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));
  // R7: the wait-unit request is a single-cycle pulse
  a_r7_sl_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    sl_start |=> !sl_start);
  // R3, R5: every command boundary lies on an even word
  a_r5_even_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_NEXT |-> !ptr[0]);
  // R8: the error flag rises only after decoding an unknown opcode
  a_r8_err_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_r) |-> $past(state) == S_EXEC && $past(kind) == K_BAD);
endmodule

// File: rtl/regcmd_exec.sv
module regcmd_exec
  import regcmd_pkg::*;
#(
  parameter int LINE_W       = 4,
  parameter int TICKS_PER_US = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_enable,
  input  logic              ctl_halt,
  input  logic              ctl_tail_we,
  input  logic [LINE_W-1:0] ctl_head,
  input  logic [LINE_W-1:0] ctl_tail,
  output logic              busy,
  output logic              err,
  output logic              mem_rd_valid,
  input  logic              mem_rd_ready,
  output logic [LINE_W+3:0] mem_rd_addr,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [19:0]       wr_addr,
  output logic [31:0]       wr_data,
  output logic [3:0]        wr_be,
  output logic              sl_start,
  output logic [2:0]        sl_op,
  output logic [31:0]       sl_lo,
  output logic [19:0]       sl_hi,
  input  logic              sl_done
);
  logic [7:0]  opcode;
  kind_e       kind;
  logic        tmr_load, tmr_run, tmr_done;
  logic [31:0] tmr_count;

  regcmd_decode u_decode (
    .opcode (opcode),
    .kind   (kind)
  );

  regcmd_usec_timer #(.TICKS_PER_US(TICKS_PER_US)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (tmr_load),
    .run   (tmr_run),
    .count (tmr_count),
    .done  (tmr_done)
  );

  regcmd_core #(.LINE_W(LINE_W)) u_core (
    .clk           (clk),
    .rst_n         (rst_n),
    .ctl_enable    (ctl_enable),
    .ctl_halt      (ctl_halt),
    .ctl_tail_we   (ctl_tail_we),
    .ctl_head      (ctl_head),
    .ctl_tail      (ctl_tail),
    .busy          (busy),
    .err           (err),
    .mem_rd_valid  (mem_rd_valid),
    .mem_rd_ready  (mem_rd_ready),
    .mem_rd_addr   (mem_rd_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .wr_valid      (wr_valid),
    .wr_ready      (wr_ready),
    .wr_addr       (wr_addr),
    .wr_data       (wr_data),
    .wr_be         (wr_be),
    .sl_start      (sl_start),
    .sl_op         (sl_op),
    .sl_lo         (sl_lo),
    .sl_hi         (sl_hi),
    .sl_done       (sl_done),
    .opcode        (opcode),
    .kind          (kind),
    .tmr_load      (tmr_load),
    .tmr_run       (tmr_run),
    .tmr_count     (tmr_count),
    .tmr_done      (tmr_done)
  );
endmodule

// File: tb/regcmd_exec_bench.sv
module regcmd_exec_bench;
  localparam int LW = 4;
  localparam int TK = 5;
  localparam int NV = 8;

  // vector table: operand word, opcode word, expected writes, expected err
  localparam logic [31:0] VW0 [NV] = '{32'h0, 32'h11223344, 32'hA5A5A5A5, 32'hDEADBEEF,
                                      32'h12345678, 32'h0, 32'h0, 32'hCAFEF00D};
  localparam logic [31:0] VW1 [NV] = '{32'h00000000, 32'h01F00123, 32'h01300456, 32'h018FFFFF,
                                      32'h08000010, 32'h07000000, 32'h0A000000, 32'h01500ABC};
  localparam int          VNW [NV] = '{0, 1, 1, 1, 0, 0, 0, 1};
  localparam logic        VER [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_enable = 1'b0, ctl_halt = 1'b0, ctl_tail_we = 1'b0;
  logic [LW-1:0] ctl_head = '0, ctl_tail = '0;
  logic busy, err, mem_rd_valid, wr_valid, sl_start;
  logic mem_rd_ready = 1'b1, wr_ready = 1'b1, sl_done = 1'b0;
  logic [LW+3:0] mem_rd_addr;
  logic mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic [19:0] wr_addr, sl_hi;
  logic [31:0] wr_data, sl_lo;
  logic [3:0]  wr_be;
  logic [2:0]  sl_op;

  logic [31:0] mem [256];
  logic [19:0] la [64];
  logic [31:0] ld [64];
  logic [3:0]  lb [64];
  int nlog = 0;
  int nchk = 0, nfail = 0;
  bit reported = 1'b0;

  always #5 clk = ~clk;

  regcmd_exec #(.LINE_W(LW), .TICKS_PER_US(TK)) u_regcmd_exec (
    .clk(clk), .rst_n(rst_n), .ctl_enable(ctl_enable), .ctl_halt(ctl_halt),
    .ctl_tail_we(ctl_tail_we), .ctl_head(ctl_head), .ctl_tail(ctl_tail),
    .busy(busy), .err(err), .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
    .mem_rd_addr(mem_rd_addr), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_be(wr_be), .sl_start(sl_start), .sl_op(sl_op), .sl_lo(sl_lo), .sl_hi(sl_hi),
    .sl_done(sl_done)
  );

  always @(posedge clk) begin
    mem_rsp_valid <= mem_rd_valid && mem_rd_ready;
    mem_rsp_data  <= mem[mem_rd_addr];
    if (wr_valid && wr_ready && nlog < 64) begin
      la[nlog] <= wr_addr;
      ld[nlog] <= wr_data;
      lb[nlog] <= wr_be;
      nlog     <= nlog + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
  endtask

  task automatic start(input int h, input int t, input bit en);
    @(negedge clk);
    ctl_head = LW'(h); ctl_tail = LW'(t);
    ctl_enable = en; ctl_tail_we = 1'b1;
    @(negedge clk);
    ctl_tail_we = 1'b0; ctl_enable = 1'b1;
  endtask

  task automatic wait_idle(output int cyc);
    cyc = 0;
    while (busy && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
    if (busy) chk(1'b0, "R2", "run did not end", 32'(cyc), 32'd0);
  endtask

  task automatic run(input int h, input int t, output int cyc);
    start(h, t, 1'b1);
    wait_idle(cyc);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 200000, 0);
    report();
    $finish;
  end

  initial begin
    int cyc, cyc0, base;
    clear_mem();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk(!busy, "R1", "busy", 32'(busy), 0);
    chk(!err, "R1", "err", 32'(err), 0);
    chk(!wr_valid && !mem_rd_valid && !sl_start, "R1", "outputs quiet",
        {29'd0, wr_valid, mem_rd_valid, sl_start}, 0);

    // R2: tail write without enable starts nothing
    mem[0] = 32'h1; mem[1] = 32'h01F00001;
    start(0, 1, 1'b0);
    chk(!busy, "R2", "start without enable", 32'(busy), 0);
    repeat (10) @(negedge clk);
    chk(nlog == 0, "R2", "no write without enable", 32'(nlog), 0);

    // vector table: single commands in line 0 (R3 R4 R8)
    for (int v = 0; v < NV; v++) begin
      clear_mem();
      mem[0] = VW0[v]; mem[1] = VW1[v];
      base = nlog;
      run(0, 1, cyc);
      chk(nlog - base == VNW[v], "R4", "write count", 32'(nlog - base), 32'(VNW[v]));
      if (VNW[v] == 1 && nlog > base) begin
        chk(la[base] == VW1[v][19:0], "R4", "wr_addr", {12'd0, la[base]}, {12'd0, VW1[v][19:0]});
        chk(ld[base] == VW0[v], "R4", "wr_data", ld[base], VW0[v]);
        chk(lb[base] == VW1[v][23:20], "R4", "wr_be", {28'd0, lb[base]}, {28'd0, VW1[v][23:20]});
      end
      chk(err == VER[v], "R8", "err flag", 32'(err), 32'(VER[v]));
    end

    // R2: empty run, head equals tail
    clear_mem();
    mem[16] = 32'h9; mem[17] = 32'h01F00009;
    base = nlog;
    run(1, 1, cyc);
    chk(nlog == base, "R2", "empty run writes", 32'(nlog - base), 0);

    // R2: nonzero head skips earlier lines
    clear_mem();
    mem[0] = 32'h1; mem[1] = 32'h01F00999;
    mem[32] = 32'h77; mem[33] = 32'h01F00444;
    base = nlog;
    run(2, 3, cyc);
    chk(nlog - base == 1, "R2", "head offset count", 32'(nlog - base), 1);
    if (nlog > base) chk(la[base] == 20'h444, "R2", "head offset addr", {12'd0, la[base]}, 32'h444);

    // R3 R2: two commands, no-op, zero fill, crossing into the second line
    clear_mem();
    mem[0] = 32'hAAAA0001; mem[1] = 32'h01F00100;
    mem[2] = 32'h0;        mem[3] = 32'h00000000;
    mem[16] = 32'hBBBB0002; mem[17] = 32'h01100101;
    base = nlog;
    run(0, 2, cyc);
    chk(nlog - base == 2, "R3", "two writes across lines", 32'(nlog - base), 2);
    if (nlog - base == 2) begin
      chk(ld[base] == 32'hAAAA0001, "R3", "first in order", ld[base], 32'hAAAA0001);
      chk(la[base+1] == 20'h101 && lb[base+1] == 4'h1, "R3", "second addr", {12'd0, la[base+1]}, 32'h101);
    end

    // R5: odd burst with pad, then a direct write
    clear_mem();
    mem[0] = 3; mem[1] = 32'h09000200;
    mem[2] = 32'hD0; mem[3] = 32'hD1; mem[4] = 32'hD2; mem[5] = 32'h0;
    mem[6] = 32'hE0; mem[7] = 32'h01F00300;
    base = nlog;
    run(0, 1, cyc);
    chk(nlog - base == 4, "R5", "odd burst count", 32'(nlog - base), 4);
    if (nlog - base == 4) begin
      for (int k = 0; k < 3; k++) begin
        chk(la[base+k] == 20'h200 && lb[base+k] == 4'hF, "R5", "burst addr/be", {12'd0, la[base+k]}, 32'h200);
        chk(ld[base+k] == 32'hD0 + k, "R5", "burst data order", ld[base+k], 32'hD0 + k);
      end
      chk(la[base+3] == 20'h300 && ld[base+3] == 32'hE0, "R5", "after pad", ld[base+3], 32'hE0);
    end
    chk(!err, "R5", "no err after pad", 32'(err), 0);

    // R5: even burst, no pad
    clear_mem();
    mem[0] = 2; mem[1] = 32'h09000210; mem[2] = 32'hF0; mem[3] = 32'hF1;
    mem[4] = 32'hF2; mem[5] = 32'h01F00310;
    base = nlog;
    run(0, 1, cyc);
    chk(nlog - base == 3, "R5", "even burst count", 32'(nlog - base), 3);
    if (nlog - base == 3) chk(la[base+2] == 20'h310 && ld[base+2] == 32'hF2, "R5", "after even", ld[base+2], 32'hF2);

    // R5: zero-count burst
    clear_mem();
    mem[0] = 0; mem[1] = 32'h09000220; mem[2] = 32'h5; mem[3] = 32'h01F00320;
    base = nlog;
    run(0, 1, cyc);
    chk(nlog - base == 1, "R5", "zero burst count", 32'(nlog - base), 1);
    if (nlog > base) chk(la[base] == 20'h320, "R5", "zero burst next", {12'd0, la[base]}, 32'h320);

    // R8: unknown opcode skipped as two words
    clear_mem();
    mem[0] = 32'h3; mem[1] = 32'h0B000000; mem[2] = 32'h66; mem[3] = 32'h01F00330;
    base = nlog;
    run(0, 1, cyc);
    chk(err, "R8", "err on 0x0B", 32'(err), 1);
    chk(nlog - base == 1 && la[base] == 20'h330, "R8", "skip two words", 32'(nlog - base), 1);

    // R6: microsecond wait length
    clear_mem();
    mem[0] = 0; mem[1] = 32'h02000000;
    run(0, 1, cyc0);
    mem[0] = 7;
    run(0, 1, cyc);
    chk(cyc - cyc0 == 7 * TK, "R6", "wait cycles", 32'(cyc - cyc0), 32'(7 * TK));

    // R7: scanline wait handshake
    clear_mem();
    mem[0] = 32'h00120034; mem[1] = 32'h05000ABC; mem[2] = 32'h99; mem[3] = 32'h01F00340;
    base = nlog;
    start(0, 1, 1'b1);
    cyc = 0;
    while (!sl_start && cyc < 50) begin @(negedge clk); cyc++; end
    chk(sl_start, "R7", "sl_start seen", 32'(sl_start), 1);
    chk(sl_op == 3'd5 && sl_lo == 32'h00120034 && sl_hi == 20'h00ABC, "R7", "wait fields",
        sl_lo, 32'h00120034);
    repeat (10) @(negedge clk);
    chk(busy && nlog == base, "R7", "held until done", 32'(nlog - base), 0);
    sl_done = 1'b1;
    @(negedge clk);
    sl_done = 1'b0;
    wait_idle(cyc);
    chk(nlog - base == 1 && la[base] == 20'h340, "R7", "write after done", 32'(nlog - base), 1);

    // R9: write back-pressure
    clear_mem();
    mem[0] = 32'h13572468; mem[1] = 32'h01C00350;
    wr_ready = 1'b0;
    base = nlog;
    start(0, 1, 1'b1);
    cyc = 0;
    while (!wr_valid && cyc < 50) begin @(negedge clk); cyc++; end
    repeat (5) @(negedge clk);
    chk(wr_valid && wr_addr == 20'h350 && wr_data == 32'h13572468 && wr_be == 4'hC,
        "R9", "held payload", wr_data, 32'h13572468);
    chk(nlog == base, "R9", "no accept while stalled", 32'(nlog - base), 0);
    wr_ready = 1'b1;
    wait_idle(cyc);
    chk(nlog - base == 1, "R9", "single accept", 32'(nlog - base), 1);

    // R10: halt without enable ignored, halt with enable stops
    clear_mem();
    mem[0] = 1000; mem[1] = 32'h02000000; mem[2] = 32'h55; mem[3] = 32'h01F00777;
    base = nlog;
    start(0, 1, 1'b1);
    repeat (20) @(negedge clk);
    ctl_enable = 1'b0; ctl_halt = 1'b1;
    @(negedge clk);
    ctl_halt = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy, "R10", "halt without enable ignored", 32'(busy), 1);
    ctl_enable = 1'b1; ctl_halt = 1'b1;
    @(negedge clk);
    ctl_halt = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy, "R10", "halted", 32'(busy), 0);
    repeat (20) @(negedge clk);
    chk(nlog == base, "R10", "no write after halt", 32'(nlog - base), 0);

    report();
    $finish;
  end
endmodule